// File: doc/BRIEF.md
# Programmable Dot Clock Divider

This block derives a pixel-rate clock enable and a matching square-wave level for two display channels, main and sub, from one of three input tick sources. Everything runs in a single clock domain. Each input source arrives as a one-cycle tick strobe, and no real clock tree is switched. A control register picks the source and holds one divider field per channel. Two 32-bit pattern registers per channel form a 64-bit ring whose low `m` bits set the output waveform. Writing the stop register freezes both channels, and its readback shows whether the dot clock has really halted.

Software programs the stop bit first, then the patterns and the control register, and then clears the stop bit. While a channel is running, a new divider value or pattern waits for the end of the current period and then takes over, so no shortened pulse appears on the output. For a plain square wave, software writes a mask with the low `m/2` bits set into the low pattern word and zero into the high word. The result is a waveform of about 50% duty over `m` ticks.

Top module: `dotclk_gen`

## Requirements
- R1: After reset, `dot_en`, `dot_lvl` and `stop_rdbk` are all 0. The control register resets to 0, so both channels are disabled.
- R2: Control register (address 0) bits [17:16] select the tick source: 0 selects `bus_tick`, 1 selects `periph_tick`, 2 selects `ext_tick`, and 3 selects none. A tick on a source that is not selected advances neither channel.
- R3: The main channel's divider field is control bits [7:0] and drives output bit 0. The sub channel's field is control bits [15:8] and drives output bit 1. Each channel behaves independently of the other's field.
- R4: For a field with bit 6 clear and m = bits [5:0] nonzero, the pattern is P = {high word, low word}. Main uses address 2 for the high word and 3 for the low word; sub uses 4 and 5. On the n-th counted tick after a start, `dot_lvl` becomes P[n mod m] in the cycle after that tick. The level holds while no tick arrives.
- R5: In divider mode, `dot_en` is high for exactly the cycle after each counted tick that falls at ring position 0. That gives one pulse per m ticks, and it is 0 otherwise.
- R6: A field with bit 6 set is bypass. In the cycle after each clock edge, `dot_en` and `dot_lvl` both equal the selected tick sampled at that edge.
- R7: A field with bit 6 clear and bits [5:0] zero disables the channel: its `dot_en` and `dot_lvl` stay 0. Field bit 7 is ignored.
- R8: A divider or pattern change written while a channel is running takes effect only after the tick that completes the current period. The remaining ticks of that period still use the old pattern and ratio.
- R9: Writing data bit 0 = 1 to address 1 halts both channels. From the second cycle after the write, both outputs are 0 and `stop_rdbk` reads 1. Writing 0 restarts the channels: the first tick that counts is the one at the edge after the write, and it counts at ring position 0. `stop_rdbk` reads 0 from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | Tick strobe of source 0 |
| periph_tick | input | 1 | Tick strobe of source 1 |
| ext_tick | input | 1 | Tick strobe of source 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 stop, 2..5 patterns) |
| wr_data | input | 32 | Register write data |
| stop_rdbk | output | 1 | 1 while the dot clock is halted |
| dot_en | output | 2 | Per-channel clock-enable pulse (bit 0 main, bit 1 sub) |
| dot_lvl | output | 2 | Per-channel square-wave level |

## Verification
Every channel output is registered, so a tick taken at one edge shows up on `dot_en` and `dot_lvl` in the cycle that follows. The bench drives ticks and writes at the falling edge and samples one falling edge after each rising edge, comparing against P[n mod m], counted from the restart that the stop write triggers. The stop bit has a longer latency: a halt or restart appears on the outputs and on `stop_rdbk` two edges after the write, and the bench samples both the intermediate cycle and the settled one. For deferred changes, the bench pauses the ticks partway through a period, rewrites the settings, and then checks the old pattern's remaining positions before the new one starts.

// File: rtl/dotclk_pkg.sv
// Shared constants and types for the dot clock divider.
// Assumes a 32-bit register data path and an 8-bit divider field per channel.
package dotclk_pkg;

    // Tick source encoding held in the control register
    typedef enum logic [1:0] {
        SRC_BUS    = 2'd0,
        SRC_PERIPH = 2'd1,
        SRC_EXT    = 2'd2,
        SRC_NONE   = 2'd3
    } src_sel_e;

    localparam int DIV_W     = 8;   // width of one channel's divider field
    localparam int BYP_BIT   = 6;   // divider field bit that requests bypass
    localparam int SEL_LSB   = 16;  // low bit of the source select field
    localparam int ADDR_CTRL = 0;   // control register address
    localparam int ADDR_STOP = 1;   // stop register address
    localparam int ADDR_PAT0 = 2;   // first pattern register address

endpackage

// File: rtl/dotclk_regs.sv
// Register file for the dot clock divider.
// Holds the control word (source select plus per-channel divider fields),
// the stop request bit and two pattern words per channel.
// Assumes NCH * DIV_W <= SEL_LSB and that all addresses fit in ADDR_W bits.
module dotclk_regs
    import dotclk_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output src_sel_e                        sel_o,
    output logic [NCH-1:0][DIV_W-1:0]       div_o,
    output logic [NCH-1:0][2*DATA_W-1:0]    pat_o,
    output logic                            stop_o
);

    localparam int PAT_W = 2 * DATA_W;

    logic ctrl_hit;
    logic stop_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign stop_hit = wr_en && (wr_addr == ADDR_W'(ADDR_STOP));

    // Source select field of the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= SRC_BUS;
        end else if (ctrl_hit) begin
            sel_o <= src_sel_e'(wr_data[SEL_LSB +: 2]);
        end
    end

    // Stop request bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_o <= 1'b0;
        end else if (stop_hit) begin
            stop_o <= wr_data[0];
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        localparam int HI_ADDR = ADDR_PAT0 + 2 * gi;
        localparam int LO_ADDR = ADDR_PAT0 + 2 * gi + 1;

        logic [DATA_W-1:0] hi_q;
        logic [DATA_W-1:0] lo_q;

        // Divider field of this channel inside the control word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_o[gi] <= '0;
            end else if (ctrl_hit) begin
                div_o[gi] <= wr_data[gi*DIV_W +: DIV_W];
            end
        end

        // Pattern words of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(HI_ADDR)) hi_q <= wr_data;
                if (wr_addr == ADDR_W'(LO_ADDR)) lo_q <= wr_data;
            end
        end

        assign pat_o[gi] = PAT_W'({hi_q, lo_q});
    end

endmodule

// File: rtl/dotclk_src.sv
// Tick source selection and stop gating.
// Picks one of three tick strobes and masks it while a stop is requested.
// Also tracks the settled halt state that software reads back.
module dotclk_src
    import dotclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bus_tick,
    input  logic     periph_tick,
    input  logic     ext_tick,
    input  src_sel_e sel,
    input  logic     stop_req,
    output logic     tick_o,
    output logic     stopped_o
);

    logic picked;

    // Choose the tick strobe named by the select field
    always_comb begin
        case (sel)
            SRC_BUS:    picked = bus_tick;
            SRC_PERIPH: picked = periph_tick;
            SRC_EXT:    picked = ext_tick;
            default:    picked = 1'b0;
        endcase
    end

    assign tick_o = picked && !stop_req;

    // Settled halt state, one cycle behind the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_o <= 1'b0;
        end else begin
            stopped_o <= stop_req;
        end
    end

endmodule

// File: rtl/dotclk_chan.sv
// One dot clock channel: a pattern ring walked by a pointer that wraps
// after m ticks, with bypass and disable encodings of the divider field.
// New settings are loaded only at a wrap, while halted, or while the active
// setting is bypass or disabled, so a running period is never cut short.
// Assumes BYP_BIT bits of ratio fit inside PAT_W pattern bits.
module dotclk_chan #(
    parameter int DIV_W   = 8,
    parameter int PAT_W   = 64,
    parameter int BYP_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               halt,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [PAT_W-1:0]   cfg_pat,
    output logic               en_o,
    output logic               lvl_o,
    output logic [BYP_BIT-1:0] ptr_o,
    output logic               byp_o,
    output logic [BYP_BIT-1:0] m_o
);

    localparam int CNT_W = BYP_BIT;

    logic [BYP_BIT:0]   act_q;
    logic [PAT_W-1:0]   pat_q;
    logic [CNT_W-1:0]   ptr_q;
    logic [CNT_W-1:0]   act_m;
    logic               act_byp;
    logic               act_off;
    logic               at_last;
    logic               step;
    logic               wrap;
    logic               reload;
    logic               unused_div_hi;

    assign act_m   = act_q[CNT_W-1:0];
    assign act_byp = act_q[BYP_BIT];
    assign act_off = !act_byp && (act_m == '0);
    assign at_last = (ptr_q == act_m - 1'b1);
    assign step    = tick && !halt && !act_byp && !act_off;
    assign wrap    = step && at_last;
    assign reload  = halt || act_off || act_byp || wrap;

    assign unused_div_hi = ^cfg_div[DIV_W-1:BYP_BIT+1];

    // Active setting, refreshed only at safe points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            pat_q <= '0;
        end else if (reload) begin
            act_q <= cfg_div[BYP_BIT:0];
            pat_q <= cfg_pat;
        end
    end

    // Ring pointer, advanced by counted ticks and wrapped after m of them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (halt || act_off || act_byp) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= at_last ? '0 : ptr_q + 1'b1;
        end
    end

    // Registered enable pulse and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            lvl_o <= 1'b0;
        end else if (halt || act_off) begin
            en_o  <= 1'b0;
            lvl_o <= 1'b0;
        end else if (act_byp) begin
            en_o  <= tick;
            lvl_o <= tick;
        end else if (step) begin
            en_o  <= (ptr_q == '0);
            lvl_o <= pat_q[ptr_q];
        end else begin
            en_o  <= 1'b0;
        end
    end

    assign ptr_o = ptr_q;
    assign byp_o = act_byp;
    assign m_o   = act_m;

endmodule

// File: rtl/dotclk_gen.sv
// Top of the dot clock divider: registers, source selection and one
// pattern channel per display output. Single clock domain; tick inputs
// are one-cycle strobes synchronous to clk.
module dotclk_gen
    import dotclk_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              periph_tick,
    input  logic              ext_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              stop_rdbk,
    output logic [NCH-1:0]    dot_en,
    output logic [NCH-1:0]    dot_lvl
);

    localparam int PAT_W = 2 * DATA_W;
    localparam int CNT_W = BYP_BIT;

    src_sel_e                   sel;
    logic [NCH-1:0][DIV_W-1:0]  div_cfg;
    logic [NCH-1:0][PAT_W-1:0]  pat_cfg;
    logic                       stop_req;
    logic                       tick_g;
    logic [NCH-1:0][CNT_W-1:0]  ch_ptr;
    logic [NCH-1:0]             ch_byp;
    logic [NCH-1:0][CNT_W-1:0]  ch_m;

    dotclk_regs #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_o   (sel),
        .div_o   (div_cfg),
        .pat_o   (pat_cfg),
        .stop_o  (stop_req)
    );

    dotclk_src u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_tick    (bus_tick),
        .periph_tick (periph_tick),
        .ext_tick    (ext_tick),
        .sel         (sel),
        .stop_req    (stop_req),
        .tick_o      (tick_g),
        .stopped_o   (stop_rdbk)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        dotclk_chan #(
            .DIV_W   (DIV_W),
            .PAT_W   (PAT_W),
            .BYP_BIT (BYP_BIT)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_g),
            .halt    (stop_req),
            .cfg_div (div_cfg[gi]),
            .cfg_pat (pat_cfg[gi]),
            .en_o    (dot_en[gi]),
            .lvl_o   (dot_lvl[gi]),
            .ptr_o   (ch_ptr[gi]),
            .byp_o   (ch_byp[gi]),
            .m_o     (ch_m[gi])
        );
    end

endmodule

// File: rtl/dotclk_gen_chk.sv
// Property checker for the dot clock divider, bound to the top module.
module dotclk_gen_chk #(
    parameter int NCH    = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic                       stop_rdbk,
    input logic                       tick_g,
    input logic [NCH-1:0]             dot_en,
    input logic [NCH-1:0]             dot_lvl,
    input logic [NCH-1:0][CNT_W-1:0]  ch_ptr,
    input logic [NCH-1:0]             ch_byp,
    input logic [NCH-1:0][CNT_W-1:0]  ch_m
);

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rdbk |-> (dot_en == '0 && dot_lvl == '0)); // R9

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_en != '0) |-> $past(tick_g)); // R2

    AST_STOP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1)) |=> ##1 (stop_rdbk == $past(wr_data[0], 2))); // R9

    for (genvar gi = 0; gi < NCH; gi++) begin : g_prop
        AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_byp[gi] && ch_m[gi] != '0) |-> (ch_ptr[gi] < ch_m[gi])); // R4

        AST_EN_AT_RING_START: assert property (@(posedge clk) disable iff (!rst_n)
            (dot_en[gi] && !$past(ch_byp[gi])) |-> ($past(ch_ptr[gi]) == '0)); // R5

        AST_BYPASS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_byp[gi]) |-> (dot_en[gi] == dot_lvl[gi])); // R6
    end

endmodule

bind dotclk_gen dotclk_gen_chk #(
    .NCH    (NCH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .stop_rdbk (stop_rdbk),
    .tick_g    (tick_g),
    .dot_en    (dot_en),
    .dot_lvl   (dot_lvl),
    .ch_ptr    (ch_ptr),
    .ch_byp    (ch_byp),
    .ch_m      (ch_m)
);

// File: tb/dotclk_gen_test.sv
// Self-checking bench for dotclk_gen: sweeps ratios, patterns, sources,
// bypass, disable, deferred updates and stop/restart.
module dotclk_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ticks = 3'b000;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        stop_rdbk;
    logic [1:0]  dot_en;
    logic [1:0]  dot_lvl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dotclk_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_tick    (ticks[0]),
        .periph_tick (ticks[1]),
        .ext_tick    (ticks[2]),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .stop_rdbk   (stop_rdbk),
        .dot_en      (dot_en),
        .dot_lvl     (dot_lvl)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Halt, program everything, then restart with the given tick inputs.
    task automatic cfg_go(input logic [31:0] ctrl,
                          input logic [31:0] h0, input logic [31:0] l0,
                          input logic [31:0] h1, input logic [31:0] l1,
                          input logic [2:0] tk);
        ticks = 3'b000;
        wr(3'd1, 32'd1);
        wr(3'd2, h0); wr(3'd3, l0);
        wr(3'd4, h1); wr(3'd5, l1);
        wr(3'd0, ctrl);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd0; ticks = tk;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [63:0] half_mask(input int m);
        return (64'd1 << (m / 2)) - 64'd1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with ticks toggling
        ticks = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dot_en", dot_en, 0);
        chk("R1", "dot_lvl", dot_lvl, 0);
        chk("R1", "stop_rdbk", stop_rdbk, 0);
        @(negedge clk);
        chk("R1", "dot_en idle", dot_en, 0);
        ticks = 3'b000;

        // R4 R5: main channel ratio sweep with the half-duty pattern
        for (int m = 1; m <= 12; m++) begin
            logic [63:0] p;
            p = half_mask(m);
            cfg_go(32'(m), p[63:32], p[31:0], 0, 0, 3'b001);
            for (int n = 0; n < 2 * m + 1; n++) begin
                @(negedge clk);
                chk("R4", $sformatf("main m=%0d n=%0d lvl", m, n), dot_lvl[0], p[n % m]);
                chk("R5", $sformatf("main m=%0d n=%0d en", m, n), dot_en[0], (n % m) == 0);
            end
            ticks = 3'b000;
        end

        // R3 R4 R7: sub channel wide patterns on the peripheral source
        begin
            int ms [5] = '{1, 5, 33, 40, 63};
            logic [63:0] ps;
            logic [63:0] pm;
            ps = 64'hC3A5_0F96_5A3C_E187;
            pm = half_mask(7);
            for (int k = 0; k < 5; k++) begin
                int mm;
                mm = (k < 2) ? 0 : 7;
                cfg_go((32'd1 << 16) | (32'(ms[k]) << 8) | 32'(mm),
                       pm[63:32], pm[31:0], ps[63:32], ps[31:0], 3'b010);
                for (int n = 0; n < 70; n++) begin
                    @(negedge clk);
                    chk("R4", $sformatf("sub m=%0d n=%0d lvl", ms[k], n), dot_lvl[1], ps[n % ms[k]]);
                    chk("R5", $sformatf("sub m=%0d n=%0d en", ms[k], n), dot_en[1], (n % ms[k]) == 0);
                    if (mm == 0) begin
                        chk("R7", "main off lvl", dot_lvl[0], 0);
                        chk("R7", "main off en", dot_en[0], 0);
                    end else begin
                        chk("R3", "main beside sub lvl", dot_lvl[0], pm[n % mm]);
                        chk("R3", "main beside sub en", dot_en[0], (n % mm) == 0);
                    end
                end
                ticks = 3'b000;
            end
        end

        // R2: only the selected source advances the ring
        for (int s = 0; s < 4; s++) begin
            cfg_go((32'(s) << 16) | 32'd2, 0, 1, 0, 0, 3'b000);
            for (int j = 0; j < 3; j++) begin
                int cnt;
                cnt = 0;
                ticks = 3'(1 << j);
                repeat (4) begin
                    @(negedge clk);
                    cnt += int'(dot_en[0]);
                end
                ticks = 3'b000;
                chk("R2", $sformatf("sel=%0d src=%0d pulses", s, j), cnt, (j == s) ? 2 : 0);
            end
        end

        // R6: bypass on both channels follows the tick pattern
        cfg_go(32'h0000_4045, 0, 0, 0, 0, 3'b000);
        for (int k = 0; k < 12; k++) begin
            logic tv;
            tv = (k % 3) != 0;
            ticks = {2'b00, tv};
            @(negedge clk);
            chk("R6", $sformatf("bypass k=%0d en", k), dot_en, {tv, tv});
            chk("R6", $sformatf("bypass k=%0d lvl", k), dot_lvl, {tv, tv});
        end
        ticks = 3'b000;

        // R7: zero ratio disables, bit 7 alone is ignored
        cfg_go(32'h0000_0080, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        repeat (6) begin
            @(negedge clk);
            chk("R7", "off en", dot_en, 0);
            chk("R7", "off lvl", dot_lvl, 0);
        end
        ticks = 3'b000;

        // R8: change written mid-period waits for the wrap
        cfg_go(32'd4, 0, 32'h3, 0, 0, 3'b001);
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            chk("R8", "pre-change lvl", dot_lvl[0], (32'h3 >> (n % 4)) & 1);
        end
        ticks = 3'b000;
        wr(3'd3, 32'h5);
        wr(3'd0, 32'd3);
        ticks = 3'b001;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", $sformatf("old tail k=%0d lvl", k), dot_lvl[0], (32'h3 >> (k + 1)) & 1);
            chk("R8", $sformatf("old tail k=%0d en", k), dot_en[0], 0);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R8", $sformatf("new k=%0d lvl", k), dot_lvl[0], (32'h5 >> (k % 3)) & 1);
            chk("R8", $sformatf("new k=%0d en", k), dot_en[0], (k % 3) == 0);
        end
        ticks = 3'b000;

        // R9: stop and restart timing
        cfg_go(32'd2, 0, 1, 0, 0, 3'b001);
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9", "readback lags by one", stop_rdbk, 0);
        @(negedge clk);
        chk("R9", "halted readback", stop_rdbk, 1);
        chk("R9", "halted en", dot_en, 0);
        chk("R9", "halted lvl", dot_lvl, 0);
        repeat (4) begin
            @(negedge clk);
            chk("R9", "stays halted en", dot_en, 0);
            chk("R9", "stays halted lvl", dot_lvl, 0);
        end
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9", "restart edge readback", stop_rdbk, 1);
        chk("R9", "restart edge en", dot_en[0], 0);
        @(negedge clk);
        chk("R9", "running readback", stop_rdbk, 0);
        chk("R9", "first tick en", dot_en[0], 1);
        chk("R9", "first tick lvl", dot_lvl[0], 1);
        @(negedge clk);
        chk("R9", "second tick en", dot_en[0], 0);
        chk("R9", "second tick lvl", dot_lvl[0], 0);
        ticks = 3'b000;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule